// File: doc/BRIEF.md
# Performance Counter Bank with Per-Counter Inhibit and Access Gating

This block holds the performance counters of a processor hart: a free-running cycle counter, a retired-instruction counter and a parameterised set of event counters. Every counter is 64 bits wide. Each event counter has its own selector register that picks one of the platform's event pulse lines. Two 32-bit control words set the policy. The halt mask decides which counters stop. The visibility mask decides which counters software running below machine level may read. The two masks work independently of each other.

Software reaches the bank through a 32-bit register port. Each counter appears there as a low word and a high word. A write to one word replaces that word on the write's clock edge, and the count for that edge is dropped, so the written value is never overtaken by the writing instruction's own increment. A lower-privilege read of a counter whose visibility bit is clear returns zero and raises an illegal-instruction flag. The counter keeps counting either way. A wall-clock time value from outside the block can be read through the same port under its own visibility bit. The time value cannot be halted.

Top module: `perf_counter_bank`

## Requirements
- R1: Address bits [6:5] select the register class: 0 is a counter's bits 31:0, 1 is the same counter's bits 63:32, 2 is an event selector, and 3 is a control word. Bits [4:0] give the index: 0 cycle, 1 time, 2 retired-instruction, 3 and up the event counters. A carry out of bit 31 appears in the high word.
- R2: The cycle counter adds one on every clock edge unless halt-mask bit 0 is set.
- R3: The retired-instruction counter adds one on each edge where `retire_valid` is high. It does not count when `retire_no_count` is also high (environment calls and breakpoints). It does not count when halt-mask bit 2 is set.
- R4: Event counter n adds one on an edge where the event line chosen by its selector is high. Selector value k picks `evt_pulse[k-1]`. Selector value 0 and values above the number of lines never count.
- R5: A counter whose halt bit is set holds its value. Bit 1 of the halt mask (control index 0) always reads as zero.
- R6: A write to one word of a counter replaces only that word on the write's edge. The other word is kept, and that edge's increment is dropped, including a retirement in the same cycle.
- R7: When `csr_priv_low` is high, a read of counter index i is allowed only if bit i of the visibility mask (control index 1) is set. A refused read returns zero with `csr_illegal` high. Selector and control words are always refused at lower privilege. Machine-level reads are never refused.
- R8: A read of time index returns the matching half of `time_in`. Writes to that index are ignored.
- R9: Reading or writing either mask leaves every counter value unchanged.
- R10: After reset both masks, all selectors and all counters are zero.
- R11: Read data and the illegal flag are registered. `csr_rvalid` is high exactly in the cycle after `csr_re`. Counter indices with no counter read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_re | input | 1 | Read request for one cycle |
| csr_we | input | 1 | Write request for one cycle (machine level) |
| csr_priv_low | input | 1 | The read comes from below machine level |
| csr_addr | input | 7 | Register class [6:5] and index [4:0] |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| csr_rvalid | output | 1 | Read data is valid |
| csr_illegal | output | 1 | The read was refused (illegal instruction) |
| retire_valid | input | 1 | An instruction completes this cycle |
| retire_no_count | input | 1 | The completing instruction is an environment call or breakpoint |
| evt_pulse | input | NUM_EVENTS | Platform event pulses |
| time_in | input | 64 | Wall-clock time value |

## Verification
A broken increment path, a missed carry or a halt bit wired to the wrong counter does not raise any flag. It shows only as a wrong count, on the first read after the damage. The bench therefore loads counters with known values and reads them back after an exact number of edges, so an error of a single count is caught. A fault in the privilege gate shows on the very next read response: the illegal flag is wrong, or data leaks through on a refused read. Mask independence is checked by touching the masks between two reads of a halted counter, which must return the same value.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int CNT_W  = 64;
  localparam int HALF_W = 32;
  localparam int IDX_W  = 5;
  localparam int NSLOT  = 1 << IDX_W;

  typedef enum logic [1:0] {
    K_CNT_LO = 2'd0,
    K_CNT_HI = 2'd1,
    K_SEL    = 2'd2,
    K_CTRL   = 2'd3
  } pcb_kind_e;

  localparam int IDX_CYCLE   = 0;
  localparam int IDX_TIME    = 1;
  localparam int IDX_INSTRET = 2;
  localparam int IDX_EVT0    = 3;

  localparam int CTRL_HALT = 0;
  localparam int CTRL_VIS  = 1;

  // bit that can never be halted (wall-clock time)
  localparam logic [HALF_W-1:0] HALT_FIXED_ZERO = HALF_W'(1) << IDX_TIME;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter
  import pcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              halt_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q <= {cnt_q[CNT_W-1:HALF_W], wdata_i};
    end else if (wr_hi_i) begin
      cnt_q <= {wdata_i, cnt_q[HALF_W-1:0]};
    end else if (inc_i && !halt_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  assert_halt_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (halt_i && !wr_lo_i && !wr_hi_i) |=> (cnt_o == $past(cnt_o)));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !halt_i && !wr_lo_i && !wr_hi_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  assert_low_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_lo_i |=> (cnt_o[HALF_W-1:0] == $past(wdata_i)) &&
                (cnt_o[CNT_W-1:HALF_W] == $past(cnt_o[CNT_W-1:HALF_W])));

  assert_high_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_hi_i |=> (cnt_o[CNT_W-1:HALF_W] == $past(wdata_i)) &&
                (cnt_o[HALF_W-1:0] == $past(cnt_o[HALF_W-1:0])));
endmodule

// File: rtl/pcb_evt_select.sv
module pcb_evt_select #(
  parameter int SEL_W      = 8,
  parameter int NUM_EVENTS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic [SEL_W-1:0]      wdata_i,
  input  logic [NUM_EVENTS-1:0] evt_i,
  output logic [SEL_W-1:0]      sel_o,
  output logic                  hit_o
);
  logic [SEL_W-1:0] sel_q;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst)       sel_q <= '0;
    else if (wr_i) sel_q <= wdata_i;
  end

  // value k picks line k-1; zero and out-of-range values pick nothing
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_EVENTS; k++) begin
      if (sel_q == SEL_W'(k + 1)) hit = evt_i[k];
    end
  end

  assign sel_o = sel_q;
  assign hit_o = hit;

  assert_sel_none_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_o == '0) |-> !hit_o);

  assert_sel_range_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_o > SEL_W'(NUM_EVENTS)) |-> !hit_o);
endmodule

// File: rtl/pcb_read_port.sv
module pcb_read_port
  import pcb_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re_i,
  input  logic              priv_low_i,
  input  pcb_kind_e         kind_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CNT_W-1:0]  cnt_i [NSLOT],
  input  logic [SEL_W-1:0]  sel_i [NSLOT],
  input  logic [HALF_W-1:0] halt_i,
  input  logic [HALF_W-1:0] vis_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              illegal_o
);
  logic [HALF_W-1:0] data;
  logic              legal;

  always_comb begin
    data  = '0;
    legal = !priv_low_i;
    unique case (kind_i)
      K_CNT_LO: begin
        data  = cnt_i[idx_i][HALF_W-1:0];
        legal = !priv_low_i || vis_i[idx_i];
      end
      K_CNT_HI: begin
        data  = cnt_i[idx_i][CNT_W-1:HALF_W];
        legal = !priv_low_i || vis_i[idx_i];
      end
      K_SEL: data = {{(HALF_W-SEL_W){1'b0}}, sel_i[idx_i]};
      K_CTRL: begin
        if (idx_i == IDX_W'(CTRL_HALT))     data = halt_i;
        else if (idx_i == IDX_W'(CTRL_VIS)) data = vis_i;
      end
      default: data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      rvalid_o  <= re_i;
      illegal_o <= re_i && !legal;
      rdata_o   <= (re_i && legal) ? data : '0;
    end
  end

  assert_machine_legal_R7: assert property (@(posedge clk) disable iff (rst)
    (re_i && !priv_low_i) |=> !illegal_o);

  assert_refused_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (re_i && priv_low_i && (kind_i == K_CNT_LO || kind_i == K_CNT_HI) && !vis_i[idx_i])
      |=> (illegal_o && rdata_o == '0));

  assert_rvalid_follow_R11: assert property (@(posedge clk) disable iff (rst)
    re_i |=> rvalid_o);

  assert_rvalid_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !re_i |=> !rvalid_o);
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_EVT    = 4,
  parameter int SEL_W      = 8,
  parameter int NUM_EVENTS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  csr_re,
  input  logic                  csr_we,
  input  logic                  csr_priv_low,
  input  logic [IDX_W+1:0]      csr_addr,
  input  logic [HALF_W-1:0]     csr_wdata,
  output logic [HALF_W-1:0]     csr_rdata,
  output logic                  csr_rvalid,
  output logic                  csr_illegal,
  input  logic                  retire_valid,
  input  logic                  retire_no_count,
  input  logic [NUM_EVENTS-1:0] evt_pulse,
  input  logic [CNT_W-1:0]      time_in
);
  localparam int EVT_END = IDX_EVT0 + NUM_EVT;

  pcb_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [HALF_W-1:0] halt_q, vis_q;
  logic [NSLOT-1:0]  wr_lo, wr_hi, wr_sel;
  logic [CNT_W-1:0]  cnt_all [NSLOT];
  logic [SEL_W-1:0]  sel_all [NSLOT];
  logic              instret_inc;

  assign kind = pcb_kind_e'(csr_addr[IDX_W+1:IDX_W]);
  assign idx  = csr_addr[IDX_W-1:0];

  // one-hot write strobes per index and class
  always_comb begin
    wr_lo  = '0;
    wr_hi  = '0;
    wr_sel = '0;
    if (csr_we) begin
      if (kind == K_CNT_LO) wr_lo[idx]  = 1'b1;
      if (kind == K_CNT_HI) wr_hi[idx]  = 1'b1;
      if (kind == K_SEL)    wr_sel[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= '0;
      vis_q  <= '0;
    end else if (csr_we && kind == K_CTRL) begin
      if (idx == IDX_W'(CTRL_HALT)) halt_q <= csr_wdata & ~HALT_FIXED_ZERO;
      if (idx == IDX_W'(CTRL_VIS))  vis_q  <= csr_wdata;
    end
  end

  assign instret_inc = retire_valid && !retire_no_count;

  pcb_counter u_cycle (
    .clk(clk), .rst(rst), .inc_i(1'b1), .halt_i(halt_q[IDX_CYCLE]),
    .wr_lo_i(wr_lo[IDX_CYCLE]), .wr_hi_i(wr_hi[IDX_CYCLE]),
    .wdata_i(csr_wdata), .cnt_o(cnt_all[IDX_CYCLE])
  );

  assign cnt_all[IDX_TIME] = time_in;
  assign sel_all[IDX_CYCLE]   = '0;
  assign sel_all[IDX_TIME]    = '0;
  assign sel_all[IDX_INSTRET] = '0;

  pcb_counter u_instret (
    .clk(clk), .rst(rst), .inc_i(instret_inc), .halt_i(halt_q[IDX_INSTRET]),
    .wr_lo_i(wr_lo[IDX_INSTRET]), .wr_hi_i(wr_hi[IDX_INSTRET]),
    .wdata_i(csr_wdata), .cnt_o(cnt_all[IDX_INSTRET])
  );

  for (genvar i = IDX_EVT0; i < NSLOT; i++) begin : g_slot
    if (i < EVT_END) begin : g_evt
      logic hit;
      pcb_evt_select #(.SEL_W(SEL_W), .NUM_EVENTS(NUM_EVENTS)) u_sel (
        .clk(clk), .rst(rst), .wr_i(wr_sel[i]), .wdata_i(csr_wdata[SEL_W-1:0]),
        .evt_i(evt_pulse), .sel_o(sel_all[i]), .hit_o(hit)
      );
      pcb_counter u_cnt (
        .clk(clk), .rst(rst), .inc_i(hit), .halt_i(halt_q[i]),
        .wr_lo_i(wr_lo[i]), .wr_hi_i(wr_hi[i]),
        .wdata_i(csr_wdata), .cnt_o(cnt_all[i])
      );
    end else begin : g_absent
      assign cnt_all[i] = '0;
      assign sel_all[i] = '0;
    end
  end

  pcb_read_port #(.SEL_W(SEL_W)) u_read (
    .clk(clk), .rst(rst), .re_i(csr_re), .priv_low_i(csr_priv_low),
    .kind_i(kind), .idx_i(idx), .cnt_i(cnt_all), .sel_i(sel_all),
    .halt_i(halt_q), .vis_i(vis_q),
    .rdata_o(csr_rdata), .rvalid_o(csr_rvalid), .illegal_o(csr_illegal)
  );

  assert_time_unhaltable_R5: assert property (@(posedge clk) disable iff (rst)
    (csr_we && kind == K_CTRL && idx == IDX_W'(CTRL_HALT)) |=> !halt_q[IDX_TIME]);

  assert_mask_write_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (csr_we && kind == K_CTRL && !retire_valid && halt_q[IDX_INSTRET])
      |=> (cnt_all[IDX_INSTRET] == $past(cnt_all[IDX_INSTRET])));

  assert_no_count_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && retire_no_count && !wr_lo[IDX_INSTRET] && !wr_hi[IDX_INSTRET])
      |=> (cnt_all[IDX_INSTRET] == $past(cnt_all[IDX_INSTRET])));
endmodule

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
  localparam logic [1:0] KLO = 2'd0, KHI = 2'd1, KSEL = 2'd2, KCTL = 2'd3;
  localparam logic [63:0] TIME_VAL = 64'h1234_5678_9ABC_DEF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_re = 1'b0, csr_we = 1'b0, csr_priv_low = 1'b0;
  logic [6:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_rvalid, csr_illegal;
  logic        retire_valid = 1'b0, retire_no_count = 1'b0;
  logic [7:0]  evt_pulse = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] q_data[$];
  logic        q_ill[$];
  string       q_req[$];

  always #5 clk = ~clk;

  perf_counter_bank #(.NUM_EVT(4), .SEL_W(8), .NUM_EVENTS(8)) i_perf_counter_bank (
    .clk(clk), .rst(rst), .csr_re(csr_re), .csr_we(csr_we),
    .csr_priv_low(csr_priv_low), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid), .csr_illegal(csr_illegal),
    .retire_valid(retire_valid), .retire_no_count(retire_no_count),
    .evt_pulse(evt_pulse), .time_in(TIME_VAL)
  );

  // monitor: compares each read response with the next expected item
  always @(negedge clk) begin
    if (!rst && csr_rvalid) begin
      logic [31:0] ed; logic ei; string er;
      checks++;
      if (q_data.size() == 0) begin
        fails++;
        $display("FAIL R11: unexpected response data=%h", csr_rdata);
      end else begin
        ed = q_data.pop_front(); ei = q_ill.pop_front(); er = q_req.pop_front();
        if (csr_rdata !== ed || csr_illegal !== ei) begin
          fails++;
          $display("FAIL %s: got data=%h illegal=%b, expected data=%h illegal=%b",
                   er, csr_rdata, csr_illegal, ed, ei);
        end
      end
    end
  end

  // all tasks start and end at a falling edge, each spans one rising edge
  task automatic rd(input logic [1:0] k, input int i, input logic low,
                    input logic [31:0] exp, input logic exp_ill, input string req);
    csr_re = 1'b1; csr_priv_low = low; csr_addr = {k, 5'(i)};
    q_data.push_back(exp); q_ill.push_back(exp_ill); q_req.push_back(req);
    @(negedge clk);
    csr_re = 1'b0; csr_priv_low = 1'b0;
  endtask

  task automatic wr(input logic [1:0] k, input int i, input logic [31:0] d);
    csr_we = 1'b1; csr_addr = {k, 5'(i)}; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic retire(input logic nc);
    retire_valid = 1'b1; retire_no_count = nc;
    @(negedge clk);
    retire_valid = 1'b0; retire_no_count = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11: watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (csr_rvalid !== 1'b0) begin
      fails++; $display("FAIL R10: rvalid=%b expected 0 after reset", csr_rvalid);
    end
    // R10: reset state
    rd(KCTL, 0, 0, 32'h0, 0, "R10 halt mask");
    rd(KCTL, 1, 0, 32'h0, 0, "R10 visibility mask");
    rd(KLO, 2, 0, 32'h0, 0, "R10 instret");
    rd(KLO, 3, 0, 32'h0, 0, "R10 event counter");
    rd(KSEL, 3, 0, 32'h0, 0, "R10 selector");

    // R2 / R6: load cycle counter, then exact count
    wr(KHI, 0, 32'h0);
    wr(KLO, 0, 32'h0000_1000);
    rd(KLO, 0, 0, 32'h0000_1000, 0, "R6 cycle write visible");
    idle(3);
    rd(KLO, 0, 0, 32'h0000_1004, 0, "R2 cycle counts each edge");
    // R1: carry into the high word
    wr(KHI, 0, 32'h0);
    wr(KLO, 0, 32'hFFFF_FFFF);
    rd(KLO, 0, 0, 32'hFFFF_FFFF, 0, "R1 low word");
    rd(KHI, 0, 0, 32'h0000_0001, 0, "R1 carry into high word");

    // R5: halt the cycle counter
    wr(KCTL, 0, 32'h0000_0001);
    wr(KLO, 0, 32'd55);
    rd(KLO, 0, 0, 32'd55, 0, "R5 halted after write");
    idle(5);
    rd(KLO, 0, 0, 32'd55, 0, "R5 halted holds");
    // R9: touching masks leaves counters alone
    rd(KCTL, 1, 0, 32'h0, 0, "R9 mask read");
    wr(KCTL, 1, 32'h0);
    rd(KLO, 0, 0, 32'd55, 0, "R9 counter unchanged by mask access");

    // R7 / R8: lower-privilege gating
    rd(KLO, 0, 1, 32'h0, 1, "R7 refused cycle read");
    rd(KLO, 1, 0, TIME_VAL[31:0], 0, "R8 time low at machine level");
    rd(KHI, 1, 1, 32'h0, 1, "R8 time refused without visibility bit");
    wr(KCTL, 1, 32'h0000_0001);
    rd(KLO, 0, 1, 32'd55, 0, "R7 allowed cycle read");
    rd(KHI, 1, 1, 32'h0, 1, "R7 time still refused");
    wr(KCTL, 1, 32'h0000_0007);
    rd(KHI, 1, 1, TIME_VAL[63:32], 0, "R8 time high allowed");
    rd(KCTL, 0, 1, 32'h0, 1, "R7 control refused at lower privilege");
    rd(KSEL, 3, 1, 32'h0, 1, "R7 selector refused at lower privilege");
    wr(KLO, 1, 32'hDEAD_BEEF);
    rd(KLO, 1, 0, TIME_VAL[31:0], 0, "R8 time write ignored");

    // R3: retired instructions
    retire(0); retire(1); retire(0); retire(1); retire(0);
    rd(KLO, 2, 0, 32'd3, 0, "R3 no-count retirements skipped");
    wr(KCTL, 0, 32'h0000_0005);
    retire(0); retire(0); retire(0);
    rd(KLO, 2, 0, 32'd3, 0, "R3 halted instret holds");
    wr(KCTL, 0, 32'h0000_0001);
    // R6: write wins over the same cycle's retirement
    csr_we = 1'b1; csr_addr = {KLO, 5'd2}; csr_wdata = 32'd100; retire_valid = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; retire_valid = 1'b0;
    rd(KLO, 2, 0, 32'd100, 0, "R6 write drops same-cycle increment");
    wr(KHI, 2, 32'h0000_00A5);
    rd(KLO, 2, 0, 32'd100, 0, "R6 high write keeps low word");
    rd(KHI, 2, 0, 32'h0000_00A5, 0, "R6 high write value");
    rd(KCTL, 0, 0, 32'h0000_0001, 0, "R9 halt mask readback");
    wr(KCTL, 0, 32'hFFFF_FFFF);
    rd(KCTL, 0, 0, 32'hFFFF_FFFD, 0, "R5 time halt bit reads zero");
    wr(KCTL, 0, 32'h0000_0001);

    // R4: event selection
    wr(KSEL, 3, 32'd2);
    wr(KSEL, 4, 32'd0);
    wr(KSEL, 5, 32'd9);
    wr(KSEL, 6, 32'd8);
    rd(KSEL, 3, 0, 32'd2, 0, "R4 selector readback");
    repeat (4) pulse(8'h02);
    repeat (3) pulse(8'h01);
    pulse(8'hFF);
    rd(KLO, 3, 0, 32'd5, 0, "R4 selected line counted");
    rd(KLO, 4, 0, 32'd0, 0, "R4 selector zero never counts");
    rd(KLO, 5, 0, 32'd0, 0, "R4 out-of-range selector never counts");
    rd(KLO, 6, 0, 32'd1, 0, "R4 highest line counted");
    wr(KCTL, 0, 32'h0000_0008);
    repeat (2) pulse(8'h02);
    rd(KLO, 3, 0, 32'd5, 0, "R5 halted event counter holds");

    // R11: absent counter index
    wr(KLO, 10, 32'h1234_5678);
    rd(KLO, 10, 0, 32'h0, 0, "R11 absent counter reads zero");
    idle(3);

    checks++;
    if (q_data.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d responses missing, expected 0", q_data.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule